// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire management bus between a MAC and its PHY. Software places one packed 32-bit frame word into the frame register. If the block is idle and the speed divider is non-zero, it starts a frame: a run of ones as a preamble, then the 32 bits of the word, most significant bit first, one bit per management clock period. For a read opcode, the block stops driving the data line near the end of the frame and shifts in the 16 bits that the PHY returns. Those bits replace the low half of the same frame register.

When the last bit has been clocked, a sticky completion event is raised. Software clears it by writing a one. The interrupt line is this event gated by a mask bit. A divider value N sets the management clock period to 2·N system clocks. Software normally picks N as the ceiling of the system clock over 5 MHz, which keeps the management clock at or below 2.5 MHz.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, the frame register reads 0, and the event flag, interrupt, management clock and data-line enable are all 0.
- R2: A write to the frame register while idle, with N non-zero, sends 32 preamble ones and then frame bits 31 down to 0. Exactly 64 rising management-clock edges occur, and each driven bit is stable at its rising edge.
- R3: The management clock has a period of 2·N system clocks and stays low while idle. The event flag becomes visible exactly 128·N clocks after the clock edge that accepted the write.
- R4: A frame whose opcode field (bits 29:28) is 10 is a read. The data-line enable is low from frame bit 16 (the second turnaround bit) through bit 0. The 16 bits sampled on rising edges, MSB first, land in register bits 15:0, and bits 31:16 are kept.
- R5: A frame with any other opcode leaves the frame register unchanged at completion and drives every bit.
- R6: The event flag stays set until the clear input is pulsed. If completion and a clear fall in the same cycle, the flag ends up set.
- R7: The interrupt output is high exactly when both the event flag and the mask input are high.
- R8: A frame-register write during a transaction is ignored: neither the frame on the wire nor the register contents change.
- R9: With N = 0, a write loads the frame register but no transaction starts: the management clock stays low and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameWrEn | input | 1 | Software write strobe for the frame register |
| frameWrData | input | 32 | Frame word written by software |
| frameRd | output | 32 | Current frame register contents |
| speedDiv | input | DIV_W | Divider N; management clock period is 2·N clocks |
| evtClr | input | 1 | Write-one-to-clear strobe for the event flag |
| evtMask | input | 1 | Interrupt mask for the event flag |
| evtFlag | output | 1 | Sticky completion event |
| irq | output | 1 | Masked completion interrupt |
| mdc | output | 1 | Management clock |
| mdioIn | input | 1 | Data line as seen at the pad |
| mdioOut | output | 1 | Data value driven to the pad |
| mdioOe | output | 1 | Data-line output enable |

## Verification
Two events can land on the same cycle: the completion of a frame, which sets the event flag, and a software write-one-to-clear of that flag. The bench knows that completion comes exactly 128·N clocks after the accepting edge. It raises the clear strobe so that it is sampled on that very edge, and it expects the flag to read set afterwards. A second overlap is a frame-register write landing mid-frame. The bench injects one and judges it by the unchanged bit stream on the wire and the unchanged register result.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PREAMBLE_BITS = 32;
  localparam int FRAME_BITS    = 32;
  localparam int TOTAL_BITS    = PREAMBLE_BITS + FRAME_BITS;
  localparam int IDX_W         = $clog2(TOTAL_BITS);
  localparam int POS_W         = $clog2(FRAME_BITS);
  localparam int DATA_BITS     = 16;
  // frame field positions the serializer depends on
  localparam int OP_HI         = 29;
  localparam int OP_LO         = 28;
  localparam logic [1:0] OP_READ = 2'b10;
  // index of the second turnaround bit (frame bit 16) and of the first data bit
  localparam int RELEASE_IDX   = TOTAL_BITS - 1 - DATA_BITS;
  localparam int DATA_IDX      = TOTAL_BITS - DATA_BITS;

  typedef struct packed {
    logic             active;  // frame in progress
    logic             load;    // frame register accepts software word
    logic             rise;    // management clock rising edge this cycle
    logic             fall;    // management clock falling edge this cycle
    logic             finish;  // last falling edge of the frame
    logic [IDX_W-1:0] bitIdx;  // current bit slot, 0 = first preamble bit
  } mdioCtlT;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameWrEn,
  input  logic [DIV_W-1:0] speedDiv,
  output logic             mdc,
  output mdioCtlT          ctl
);
  logic             busy;
  logic [DIV_W-1:0] divCnt;
  logic             mdcQ;
  logic [IDX_W-1:0] bitIdx;
  logic             accept, start, tick, lastBit;

  assign accept  = frameWrEn && !busy;
  assign start   = accept && (speedDiv != '0);
  assign tick    = busy && (speedDiv != '0) && (divCnt == speedDiv - DIV_W'(1));
  assign lastBit = (bitIdx == IDX_W'(TOTAL_BITS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      divCnt <= '0;
      mdcQ   <= 1'b0;
      bitIdx <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      divCnt <= '0;
      mdcQ   <= 1'b0;
      bitIdx <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        mdcQ   <= ~mdcQ;
        if (mdcQ) begin
          if (lastBit) busy <= 1'b0;
          else         bitIdx <= bitIdx + IDX_W'(1);
        end
      end else if (speedDiv != '0) begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  assign mdc        = mdcQ;
  assign ctl.active = busy;
  assign ctl.load   = accept;
  assign ctl.rise   = tick && !mdcQ;
  assign ctl.fall   = tick && mdcQ;
  assign ctl.finish = tick && mdcQ && lastBit;
  assign ctl.bitIdx = bitIdx;

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdcQ); // R3

  AST_NO_START_DIV0: assert property (@(posedge clk) disable iff (!rstN)
    (speedDiv == '0) && !busy |=> !busy); // R9
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mdioCtlT     ctl,
  input  logic [31:0] frameWrData,
  input  logic        mdioIn,
  input  logic        evtClr,
  input  logic        evtMask,
  output logic [31:0] frameRd,
  output logic        mdioOut,
  output logic        mdioOe,
  output logic        evtFlag,
  output logic        irq
);
  logic [FRAME_BITS-1:0] frameQ;
  logic [DATA_BITS-1:0]  rxShift;
  logic                  flagQ;
  logic                  isRead, inPreamble, released, frameBit;
  logic [POS_W-1:0]      bitPos;

  assign isRead     = (frameQ[OP_HI:OP_LO] == OP_READ);
  assign inPreamble = (ctl.bitIdx < IDX_W'(PREAMBLE_BITS));
  assign bitPos     = POS_W'(IDX_W'(TOTAL_BITS - 1) - ctl.bitIdx);
  assign frameBit   = inPreamble ? 1'b1 : frameQ[bitPos];
  assign released   = isRead && (ctl.bitIdx >= IDX_W'(RELEASE_IDX));

  assign mdioOe  = ctl.active && !released;
  assign mdioOut = mdioOe && frameBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (ctl.rise && (ctl.bitIdx >= IDX_W'(DATA_IDX))) begin
      rxShift <= {rxShift[DATA_BITS-2:0], mdioIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= '0;
    end else if (ctl.load) begin
      frameQ <= frameWrData;
    end else if (ctl.finish && isRead) begin
      frameQ[DATA_BITS-1:0] <= rxShift;
    end
  end

  // completion has priority over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          flagQ <= 1'b0;
    else if (ctl.finish) flagQ <= 1'b1;
    else if (evtClr)    flagQ <= 1'b0;
  end

  assign frameRd = frameQ;
  assign evtFlag = flagQ;
  assign irq     = flagQ && evtMask;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    flagQ && !evtClr |=> flagQ); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> flagQ); // R6

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active && isRead && (ctl.bitIdx >= IDX_W'(DATA_IDX)) |-> !mdioOe); // R4

  AST_HEADER_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |=> $stable(frameQ[FRAME_BITS-1:DATA_BITS])); // R8
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameWrEn,
  input  logic [31:0]      frameWrData,
  output logic [31:0]      frameRd,
  input  logic [DIV_W-1:0] speedDiv,
  input  logic             evtClr,
  input  logic             evtMask,
  output logic             evtFlag,
  output logic             irq,
  output logic             mdc,
  input  logic             mdioIn,
  output logic             mdioOut,
  output logic             mdioOe
);
  mdioCtlT ctl;

  mdio_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameWrEn (frameWrEn),
    .speedDiv  (speedDiv),
    .mdc       (mdc),
    .ctl       (ctl)
  );

  mdio_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .frameWrData (frameWrData),
    .mdioIn      (mdioIn),
    .evtClr      (evtClr),
    .evtMask     (evtMask),
    .frameRd     (frameRd),
    .mdioOut     (mdioOut),
    .mdioOe      (mdioOe),
    .evtFlag     (evtFlag),
    .irq         (irq)
  );
endmodule

// File: tb/test_mdio_frame_master.sv
module test_mdio_frame_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 6;
  localparam int PRE = 32;
  localparam int TOTAL = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameWrEn = 1'b0;
  logic [31:0] frameWrData = '0;
  logic [31:0] frameRd;
  logic [DIV_W-1:0] speedDiv = DIV_W'(1);
  logic evtClr = 1'b0, evtMask = 1'b0;
  logic evtFlag, irq, mdc, mdioOut, mdioOe;
  logic mdioIn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_frame_master #(.DIV_W(DIV_W)) i_mdio_frame_master (
    .clk(clk), .rstN(rstN), .frameWrEn(frameWrEn), .frameWrData(frameWrData),
    .frameRd(frameRd), .speedDiv(speedDiv), .evtClr(evtClr), .evtMask(evtMask),
    .evtFlag(evtFlag), .irq(irq), .mdc(mdc), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  int errCnt = 0, chkCnt = 0;
  int edgeCnt = 0;
  logic capOut [TOTAL];
  logic capOe [TOTAL];
  logic [15:0] phyData = '0;
  logic prevMdc = 1'b0;

  // PHY model: records each rising edge, presents the next data bit after each fall
  always @(negedge clk) begin
    if (mdc && !prevMdc) begin
      if (edgeCnt < TOTAL) begin
        capOut[edgeCnt] = mdioOut;
        capOe[edgeCnt]  = mdioOe;
      end
      edgeCnt = edgeCnt + 1;
    end
    if (!mdc && prevMdc) begin
      if (edgeCnt >= TOTAL - 16 && edgeCnt < TOTAL) mdioIn = phyData[TOTAL - 1 - edgeCnt];
      else mdioIn = 1'b0;
    end
    prevMdc = mdc;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic expWire(input logic [31:0] w, input int i);
    return (i < PRE) ? 1'b1 : w[TOTAL - 1 - i];
  endfunction

  function automatic logic isReadOp(input logic [31:0] w);
    return w[29:28] == 2'b10;
  endfunction

  function automatic logic expOe(input logic [31:0] w, input int i);
    return !(isReadOp(w) && i >= TOTAL - 17);
  endfunction

  function automatic logic [31:0] expResult(input logic [31:0] w, input logic [15:0] rd);
    return isReadOp(w) ? {w[31:16], rd} : w;
  endfunction

  task automatic clearFlag();
    @(negedge clk); evtClr = 1'b1;
    @(negedge clk); evtClr = 1'b0;
    check(evtFlag == 1'b0, "R6", "flag after clear", 32'(evtFlag), 32'd0);
  endtask

  task automatic runFrame(input logic [31:0] word, input int n, input logic [15:0] rd,
                          input bit clrAtDone, input logic [31:0] injWord, input int injAt);
    int cnt;
    int wireBad, oeBad;
    phyData  = rd;
    speedDiv = DIV_W'(n);
    clearFlag();
    edgeCnt = 0;
    frameWrEn = 1'b1; frameWrData = word;
    @(negedge clk);
    frameWrEn = 1'b0;
    cnt = 1;
    while (!evtFlag && cnt < 128 * n + 50) begin
      evtClr = clrAtDone && (cnt == 128 * n);
      frameWrEn = (injAt != 0) && (cnt == injAt);
      frameWrData = ((injAt != 0) && (cnt == injAt)) ? injWord : word;
      @(negedge clk);
      cnt++;
    end
    evtClr = 1'b0; frameWrEn = 1'b0;
    check(cnt == 128 * n + 1, "R3", "completion latency", 32'(cnt), 32'(128 * n + 1));
    if (clrAtDone)
      check(evtFlag == 1'b1, "R6", "set wins over clear", 32'(evtFlag), 32'd1);
    check(edgeCnt == TOTAL, "R2", "rising edge count", 32'(edgeCnt), 32'(TOTAL));
    wireBad = 0; oeBad = 0;
    for (int i = 0; i < TOTAL; i++) begin
      if (capOe[i] != expOe(word, i)) oeBad++;
      else if (capOe[i] && capOut[i] != expWire(word, i)) wireBad++;
    end
    check(wireBad == 0, (injAt != 0) ? "R8" : "R2", "wire bits wrong", 32'(wireBad), 32'd0);
    check(oeBad == 0, isReadOp(word) ? "R4" : "R5", "enable pattern wrong", 32'(oeBad), 32'd0);
    check(frameRd == expResult(word, rd), isReadOp(word) ? "R4" : ((injAt != 0) ? "R8" : "R5"),
          "frame register", frameRd, expResult(word, rd));
    check(!mdc && !mdioOe, "R3", "idle bus after frame", {30'd0, mdc, mdioOe}, 32'd0);
  endtask

  function automatic logic [31:0] mkWord(input logic [1:0] op);
    return {2'b01, op, 5'($urandom), 5'($urandom), 2'b10, 16'($urandom)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(frameRd == 32'd0, "R1", "frame reg at reset", frameRd, 32'd0);
    check({evtFlag, irq, mdc, mdioOe} == 4'd0, "R1", "outputs at reset",
          32'({evtFlag, irq, mdc, mdioOe}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // directed read, N=1
    runFrame({2'b01, 2'b10, 5'd1, 5'd17, 2'b10, 16'h0000}, 1, 16'hA5C3, 1'b0, '0, 0);
    // R7 mask gating
    evtMask = 1'b0; @(negedge clk);
    check(irq == 1'b0, "R7", "irq masked", 32'(irq), 32'd0);
    evtMask = 1'b1; @(negedge clk);
    check(irq == 1'b1, "R7", "irq unmasked", 32'(irq), 32'd1);
    evtClr = 1'b1; @(negedge clk); evtClr = 1'b0;
    check(irq == 1'b0, "R7", "irq after clear", 32'(irq), 32'd0);

    // directed write with a mid-frame write injected, N=3
    runFrame({2'b01, 2'b01, 5'd1, 5'd20, 2'b10, 16'h24F2}, 3, 16'hFFFF, 1'b0,
             32'h5A5A_5A5A, 100);
    // directed read with clear colliding with completion, N=2
    runFrame({2'b01, 2'b10, 5'd3, 5'd2, 2'b10, 16'h1234}, 2, 16'h8001, 1'b1, '0, 0);
    // opcode 11 is not a read
    runFrame({2'b01, 2'b11, 5'd9, 5'd4, 2'b10, 16'hBEEF}, 1, 16'h7777, 1'b0, '0, 0);

    // random frames
    for (int k = 0; k < 8; k++) begin
      w = mkWord(($urandom % 2 == 0) ? 2'b10 : 2'b01);
      runFrame(w, 1 + int'($urandom % 4), 16'($urandom), ($urandom % 3) == 0,
               mkWord(2'b01), ($urandom % 2 == 0) ? 0 : 20 + int'($urandom % 80));
    end

    // R9 divider zero blocks start
    speedDiv = '0;
    clearFlag();
    edgeCnt = 0;
    w = 32'h6ACE_1357;
    frameWrEn = 1'b1; frameWrData = w;
    @(negedge clk); frameWrEn = 1'b0;
    repeat (300) @(negedge clk);
    check(edgeCnt == 0, "R9", "clock edges with N=0", 32'(edgeCnt), 32'd0);
    check(evtFlag == 1'b0, "R9", "no event with N=0", 32'(evtFlag), 32'd0);
    check(frameRd == w, "R9", "register loaded with N=0", frameRd, w);
    check(!mdioOe, "R9", "bus released with N=0", 32'(mdioOe), 32'd0);
    // a later frame still runs normally
    runFrame({2'b01, 2'b10, 5'd2, 5'd1, 2'b10, 16'h0}, 2, 16'h3C3C, 1'b0, '0, 0);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule